// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Nesting

This block gathers interrupt requests from four classes of source: program faults, the timer, I/O completion or error, and hardware failure. It offers a single request line and a handler vector to a processor core. The core answers with an acknowledge pulse when it takes the interrupt, and with an end-of-service pulse when the handler finishes. Saving and restoring the program context is the core's job and is not part of this block.

A mode input selects one of two policies. In sequential mode, nothing new is signalled while a service is in progress. Requests that arrive in the meantime are queued and then served in the order they arrived. In nested mode, a request of strictly higher priority than the level in service preempts it. A small stack of service levels records the preempted levels, so each completion returns to the level it interrupted. Requests of equal or lower priority are never lost: they stay pending until they can be served.

Top module: `irq_priority_ctrl`

## Requirements
- R1: After reset, `irq_o` is low, `vec_o` is 0 and `eos_err_o` is low.
- R2: A request is captured on a rising edge of its source input and stays pending until it is acknowledged. A source held high after its acknowledge raises no further request until it falls and rises again.
- R3: The class numbers are program = 0, timer = 1, I/O = 2 and hardware failure = 3. While `irq_o` is high, `vec_o` gives the class number of the offered source. The core takes that source by pulsing `ack_i`.
- R4: In sequential mode (`nest_mode_i` = 0), `irq_o` stays low from the acknowledge until the matching `eos_i` pulse. Requests that arrive in that time stay pending.
- R5: In sequential mode, pending requests are offered in the order of their rising edges, whatever their priority.
- R6: In sequential mode, requests whose edges fall in the same cycle are queued from highest to lowest priority (hardware failure, I/O, timer, program).
- R7: In nested mode (`nest_mode_i` = 1), a pending request is offered during a service only if its class number is strictly greater than that of the level in service. Equal or lower requests are held.
- R8: In nested mode, the highest pending class is offered. An `eos_i` pulse ends the innermost service and makes the preempted level current again.
- R9: An `eos_i` pulse while nothing is in service changes no other state and sets `eos_err_o`, which stays high until reset.
- R10: A further rising edge on a source that is already pending adds no second request. That source is served once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 4 | Request inputs, bit n = class n |
| nest_mode_i | input | 1 | 0 = sequential policy, 1 = priority nesting |
| ack_i | input | 1 | Core takes the offered interrupt |
| eos_i | input | 1 | Core has finished the innermost service |
| irq_o | output | 1 | An interrupt is offered |
| vec_o | output | 2 | Handler vector (class number) of the offered interrupt |
| eos_err_o | output | 1 | Sticky flag: end of service seen with nothing in service |

## Verification
The assertions check four things on every cycle:
- an acknowledge places the offered vector on top of the service stack;
- no request is offered in sequential mode while a service is open;
- any nested-mode offer during a service has a higher class than the level in service;
- the error flag sets on a stray end-of-service and stays set.

The arrival queue and the service stack never overflow, and they are checked for that too. Only the bench scenarios can show the end-to-end properties:
- arrival order across separate cycles;
- priority order within one cycle;
- return to a preempted level after several nested completions;
- the one-shot response to a held input;
- the absence of duplicate service after a repeated edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_CLASSES = 4;
    localparam int CLASS_W     = $clog2(NUM_CLASSES);

    typedef enum logic [CLASS_W-1:0] {
        CLS_PROGRAM = 2'd0,
        CLS_TIMER   = 2'd1,
        CLS_IO      = 2'd2,
        CLS_HWFAIL  = 2'd3
    } irq_class_e;
endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
    parameter int NSRC = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] fresh_o
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] pend;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [NSRC-1:0] kept;

    always_comb begin
        kept    = st_q.pend & ~clr_i;
        fresh_o = src_i & ~st_q.prev & ~kept;
        st_d.prev = src_i;
        st_d.pend = kept | fresh_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2: only one source is cleared per acknowledge
    assert_clr_onehot0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(clr_i));

    // R2: a cleared source with no new edge is no longer pending
    assert_clear_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_i != '0) && ((clr_i & src_i & ~st_q.prev) == '0)) |=> ((pend_o & $past(clr_i)) == '0));
endmodule

// File: rtl/irqc_arrival_fifo.sv
module irqc_arrival_fifo #(
    parameter int NSRC = 4,
    parameter int ID_W = $clog2(NSRC)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] push_mask_i,
    input  logic            rm_valid_i,
    input  logic [ID_W-1:0] rm_id_i,
    output logic [ID_W-1:0] head_o,
    output logic            empty_o
);
    localparam int CNT_W = $clog2(NSRC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NSRC);

    typedef struct packed {
        logic [NSRC-1:0][ID_W-1:0] ent;
        logic [CNT_W-1:0]          cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        int wp;
        st_d = st_q;
        wp   = 0;
        // drop the acknowledged id and close the gap
        for (int i = 0; i < NSRC; i++) begin
            if ((CNT_W'(i) < st_q.cnt) && !(rm_valid_i && (st_q.ent[i] == rm_id_i))) begin
                st_d.ent[wp[ID_W-1:0]] = st_q.ent[i];
                wp = wp + 1;
            end
        end
        // same-cycle arrivals go in from highest to lowest priority
        for (int j = NSRC - 1; j >= 0; j--) begin
            if (push_mask_i[j] && (wp < NSRC)) begin
                st_d.ent[wp[ID_W-1:0]] = ID_W'(j);
                wp = wp + 1;
            end
        end
        st_d.cnt = CNT_W'(wp);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign head_o  = st_q.ent[0];
    assign empty_o = (st_q.cnt == '0);

    // R10: distinct pending sources never exceed the queue size
    assert_fifo_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_MAX);
endmodule

// File: rtl/irqc_service_stack.sv
module irqc_service_stack #(
    parameter int NSRC = 4,
    parameter int ID_W = $clog2(NSRC)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      push_i,
    input  logic [ID_W-1:0]           push_id_i,
    input  logic                      pop_i,
    output logic [ID_W-1:0]           top_o,
    output logic [$clog2(NSRC+1)-1:0] depth_o
);
    localparam int DEP_W = $clog2(NSRC + 1);
    localparam logic [DEP_W-1:0] DEP_MAX = DEP_W'(NSRC);

    typedef struct packed {
        logic [NSRC-1:0][ID_W-1:0] ent;
        logic [DEP_W-1:0]          depth;
    } stk_st_t;

    stk_st_t st_d, st_q;

    always_comb begin
        logic [DEP_W-1:0] d;
        st_d = st_q;
        d    = st_q.depth;
        if (pop_i && (d != '0)) d = d - 1'b1;
        if (push_i && (d < DEP_MAX)) begin
            st_d.ent[d[ID_W-1:0]] = push_id_i;
            d = d + 1'b1;
        end
        st_d.depth = d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign depth_o = st_q.depth;
    assign top_o   = (st_q.depth == '0) ? '0 : st_q.ent[ID_W'(st_q.depth - 1'b1)];

    // R7: strict preemption bounds nesting to one level per class
    assert_stack_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(push_i && !pop_i && (st_q.depth == DEP_MAX)));

    // R9: the controller never pops an empty stack
    assert_no_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pop_i && (st_q.depth == '0)));
endmodule

// File: rtl/irq_priority_ctrl.sv
module irq_priority_ctrl #(
    parameter int NUM_SRC = irqc_pkg::NUM_CLASSES
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_SRC-1:0]         src_req_i,
    input  logic                       nest_mode_i,
    input  logic                       ack_i,
    input  logic                       eos_i,
    output logic                       irq_o,
    output logic [$clog2(NUM_SRC)-1:0] vec_o,
    output logic                       eos_err_o
);
    localparam int ID_W  = $clog2(NUM_SRC);
    localparam int DEP_W = $clog2(NUM_SRC + 1);

    typedef struct packed {
        logic eos_err;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [NUM_SRC-1:0] pend, fresh, clr;
    logic [ID_W-1:0]    fifo_head, hi_id, cand, svc_top;
    logic               fifo_empty, any_pend, in_svc, offer, take, pop;
    logic [DEP_W-1:0]   svc_depth;

    irqc_req_latch #(.NSRC(NUM_SRC)) u_latch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (src_req_i),
        .clr_i   (clr),
        .pend_o  (pend),
        .fresh_o (fresh)
    );

    irqc_arrival_fifo #(.NSRC(NUM_SRC), .ID_W(ID_W)) u_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_mask_i (fresh),
        .rm_valid_i  (take),
        .rm_id_i     (cand),
        .head_o      (fifo_head),
        .empty_o     (fifo_empty)
    );

    irqc_service_stack #(.NSRC(NUM_SRC), .ID_W(ID_W)) u_stack (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (take),
        .push_id_i (cand),
        .pop_i     (pop),
        .top_o     (svc_top),
        .depth_o   (svc_depth)
    );

    always_comb begin
        hi_id    = '0;
        any_pend = |pend;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i]) hi_id = ID_W'(i);
        end
        in_svc = (svc_depth != '0);
        if (nest_mode_i) begin
            cand  = hi_id;
            offer = any_pend && (!in_svc || (hi_id > svc_top));
        end else begin
            cand  = fifo_head;
            offer = !fifo_empty && !in_svc;
        end
        take = ack_i && offer;
        clr  = take ? (NUM_SRC'(1) << cand) : '0;
        pop  = eos_i && in_svc;
        st_d.eos_err = st_q.eos_err || (eos_i && !in_svc);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o     = offer;
    assign vec_o     = offer ? cand : '0;
    assign eos_err_o = st_q.eos_err;

    // R3: the acknowledged vector becomes the level in service
    assert_ack_pushes_vector_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o && !eos_i) |=> (svc_top == $past(vec_o)));

    // R4: nothing is offered in sequential mode during a service
    assert_seq_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!nest_mode_i && (svc_depth != '0)) |-> !irq_o);

    // R7: a nested offer during service is strictly higher
    assert_preempt_higher_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nest_mode_i && irq_o && (svc_depth != '0)) |-> (vec_o > svc_top));

    // R9: stray end of service raises the flag
    assert_stray_eos_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eos_i && (svc_depth == '0)) |=> eos_err_o);

    // R9: the flag holds until reset
    assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eos_err_o |=> eos_err_o);
endmodule

// File: tb/irq_priority_ctrl_tb.sv
module irq_priority_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src = '0;
    logic       nest = 1'b0;
    logic       ack = 1'b0;
    logic       eos = 1'b0;
    logic       irq;
    logic [1:0] vec;
    logic       err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    irq_priority_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_req_i   (src),
        .nest_mode_i (nest),
        .ack_i       (ack),
        .eos_i       (eos),
        .irq_o       (irq),
        .vec_o       (vec),
        .eos_err_o   (err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expect: -1 = no request, else the vector offered
    task automatic expect_offer(string req, int exp_vec);
        if (exp_vec < 0) check(req, int'(irq), 0);
        else check(req, int'({irq, vec}), 4 + exp_vec);
    endtask

    task automatic pulse_src(logic [3:0] m);
        src = m; step(); src = '0; step();
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_eos();
        eos = 1'b1; step(); eos = 1'b0;
    endtask

    task automatic serve(string req, int exp_vec);
        expect_offer(req, exp_vec);
        do_ack();
        do_eos();
    endtask

    task automatic t_reset();
        check("R1 irq", int'(irq), 0);
        check("R1 vec", int'(vec), 0);
        check("R1 err", int'(err), 0);
    endtask

    task automatic t_seq_order();
        nest = 1'b0;
        pulse_src(4'b0010);
        pulse_src(4'b1000);
        pulse_src(4'b0001);
        expect_offer("R5 first arrival timer", 1);
        do_ack();
        expect_offer("R4 quiet in service", -1);
        pulse_src(4'b0100);
        expect_offer("R4 new arrival held", -1);
        do_eos();
        serve("R5 second arrival hwfail", 3);
        serve("R5 third arrival program", 0);
        serve("R5 fourth arrival io", 2);
        expect_offer("R5 queue drained", -1);
    endtask

    task automatic t_seq_simul();
        nest = 1'b0;
        pulse_src(4'b1111);
        serve("R6 simultaneous hwfail", 3);
        serve("R6 simultaneous io", 2);
        serve("R6 simultaneous timer", 1);
        serve("R6 simultaneous program", 0);
        expect_offer("R6 drained", -1);
    endtask

    task automatic t_nested();
        nest = 1'b1;
        pulse_src(4'b0001);
        expect_offer("R3 program vector", 0);
        do_ack();
        pulse_src(4'b0100);
        expect_offer("R7 io preempts program", 2);
        do_ack();
        pulse_src(4'b0010);
        expect_offer("R7 timer held under io", -1);
        pulse_src(4'b1000);
        expect_offer("R7 hwfail preempts io", 3);
        do_ack();
        do_eos();
        expect_offer("R8 back to io, timer held", -1);
        do_eos();
        expect_offer("R8 back to program, timer offered", 1);
        do_ack();
        do_eos();
        expect_offer("R8 back to program level", -1);
        pulse_src(4'b0001);
        expect_offer("R7 equal program held", -1);
        do_eos();
        serve("R8 program after its level ends", 0);
        check("R9 balanced eos no error", int'(err), 0);
        pulse_src(4'b0101);
        serve("R8 highest pending io", 2);
        serve("R8 then program", 0);
        expect_offer("R8 idle", -1);
    endtask

    task automatic t_level_hold();
        nest = 1'b0;
        src = 4'b0010;
        step();
        expect_offer("R2 rise latched", 1);
        do_ack();
        do_eos();
        step(); step();
        expect_offer("R2 held level no retrigger", -1);
        src = '0; step();
        src = 4'b0010; step();
        serve("R2 new rise retriggers", 1);
        src = '0; step();
        expect_offer("R2 idle", -1);
    endtask

    task automatic t_duplicate();
        nest = 1'b0;
        pulse_src(4'b0010);
        pulse_src(4'b0010);
        pulse_src(4'b0100);
        serve("R10 timer once", 1);
        serve("R10 io next", 2);
        expect_offer("R10 no duplicate timer", -1);
    endtask

    task automatic t_stray_eos();
        do_eos();
        check("R9 stray eos flags", int'(err), 1);
        expect_offer("R9 no offer after stray eos", -1);
        nest = 1'b0;
        pulse_src(4'b0100);
        serve("R9 service intact", 2);
        check("R9 flag sticky", int'(err), 1);
    endtask

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_seq_order();
        t_seq_simul();
        t_nested();
        t_level_hold();
        t_duplicate();
        t_stray_eos();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule